// File: doc/BRIEF.md
# Debug Register Access Gate

This block stands between an APB slave port and a bank of debug registers. For each access it decides whether the access goes ahead, has its write dropped without an error, or ends with an error response. The decision depends on four things. The first is who started the access: the top address bit marks the external debugger. The other three are a software lock, an OS lock, and the power state of the core. The power state is seen both as a live power-down request and as a sticky power-down flag that is cleared by reading it.

Register offsets fall into three classes:

- **Fixed registers** always answer. These are the identity word, event catch and run control.
- **General debug registers** fail while the core is unavailable.
- **Management registers** always answer. These sit at 0xF04 and above, and include the lock, OS-lock and power-status words.

A small register model lets the gating be seen through ordinary reads. Every access completes with zero wait states.

Top module: `dbg_apb_gate`

## Requirements
- R1: After reset, the software lock is set, the OS lock is clear, and the sticky power-down flag is set. The power-status word at 0xF14 reads bit1 = sticky flag and bit0 = live request. The lock-status word at 0xFB4 reads bit1 = software lock. The OS-lock word at 0xF10 reads bit0 = OS lock.
- R2: An access with address bit 31 high bypasses the software lock, so its writes take effect.
- R3: With the software lock set and address bit 31 low, writes to any register other than the lock word at 0xFB0 are dropped without an error. With the lock clear, writes take effect whatever address bit 31 is.
- R4: A read that is held back by the software lock still returns data, but changes no state. A read of 0xF14 made that way leaves the sticky flag set.
- R5: The sticky flag is set on a rising edge of the power-down request. It is cleared only by a read of 0xF14 that is allowed to proceed. If a rising edge and such a read fall in the same cycle, the flag ends up set.
- R6: An access to a general debug register answers with an error while any of these holds: the power-down request is high, the sticky flag is set, or the OS lock is set. A write that ends in an error is discarded.
- R7: The fixed registers never return an error. These are the identity word at 0x000, event catch at 0x024 and run control at 0x090.
- R8: Offsets 0xF04 to 0xFFC never return an error. Offset 0xF00 belongs to the general class.
- R9: PREADY is high exactly when PSEL and PENABLE are both high. PSLVERR is high only when PREADY is high.
- R10: Writing the unlock key to 0xFB0 clears the software lock. Writing any other value to 0xFB0 sets it.
- R11: Bit0 of 0xF10 holds the OS lock and can be both written and read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB address; top bit marks the external debugger |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Zero-wait-state ready |
| pslverr | output | 1 | Error response |
| pwr_dn_req | input | 1 | Core power-down request |

## Verification
The hardest case to produce is a power-down rising edge that lands in the same cycle as a clearing read of the power-status word. Setting must win in that cycle. To reach it, the driver raises the power-down request at the start of the access phase of a 0xF14 read. That read still shows the old flag value. The two reads that follow show the flag set, then clear. A second hard case is the read of 0xF14 held back by the software lock, which must not clear the flag. This case is reached straight after reset, before any unlock, and it is checked by reading the word twice.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

   typedef enum logic [1:0] {
      CLS_FIXED = 2'd0,
      CLS_GEN   = 2'd1,
      CLS_MGMT  = 2'd2
   } acc_cls_e;

   localparam logic [11:0] OFS_ID       = 12'h000;
   localparam logic [11:0] OFS_ECR      = 12'h024;
   localparam logic [11:0] OFS_RCR      = 12'h090;
   localparam logic [11:0] OFS_GEN_BASE = 12'h100;
   localparam logic [11:0] OFS_MGMT_LO  = 12'hF04;
   localparam logic [11:0] OFS_OSL      = 12'hF10;
   localparam logic [11:0] OFS_PSR      = 12'hF14;
   localparam logic [11:0] OFS_LAR      = 12'hFB0;
   localparam logic [11:0] OFS_LSR      = 12'hFB4;

endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
   import dbg_gate_pkg::*;
(
   input  logic [11:0] ofs,
   output acc_cls_e    cls,
   output logic        is_lar,
   output logic        is_psr
);

   always_comb begin
      if (ofs == OFS_ID || ofs == OFS_ECR || ofs == OFS_RCR)
         cls = CLS_FIXED;
      else if (ofs >= OFS_MGMT_LO)
         cls = CLS_MGMT;
      else
         cls = CLS_GEN;
   end

   assign is_lar = (ofs == OFS_LAR);
   assign is_psr = (ofs == OFS_PSR);

endmodule

// File: rtl/dbg_access_policy.sv
module dbg_access_policy
   import dbg_gate_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     access,
   input  logic     pwrite,
   input  logic     from_ext,
   input  acc_cls_e cls,
   input  logic     is_lar,
   input  logic     is_psr,
   input  logic     pwr_dn_req,
   input  logic     os_lock,
   input  logic     sw_lock,
   output logic     err,
   output logic     wr_en,
   output logic     sticky
);

   logic pwr_q;
   logic sticky_q;
   logic fault;
   logic blocked;
   logic clr_sticky;
   logic rise;

   assign fault      = (cls == CLS_GEN) && (pwr_dn_req || sticky_q || os_lock);
   assign blocked    = sw_lock && !from_ext && !(pwrite && is_lar);
   assign err        = access && fault;
   assign wr_en      = access && pwrite && !fault && !blocked;
   assign clr_sticky = access && !pwrite && !fault && !blocked && is_psr;
   assign rise       = pwr_dn_req && !pwr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q    <= 1'b0;
         sticky_q <= 1'b1;
      end else begin
         pwr_q <= pwr_dn_req;
         if (rise)
            sticky_q <= 1'b1;
         else if (clr_sticky)
            sticky_q <= 1'b0;
      end
   end

   assign sticky = sticky_q;

   AST_STICKY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_dn_req) |=> sticky_q); // R5

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_q && !(access && !pwrite && is_psr) |=> sticky_q); // R5

   AST_OSLOCK_GEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      access && cls == CLS_GEN && os_lock |-> err && !wr_en); // R6

endmodule

// File: rtl/dbg_reg_model.sv
module dbg_reg_model
   import dbg_gate_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          NUM_GEN    = 8,
   parameter logic [31:0] ID_VALUE   = 32'h4D0B_1E57,
   parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_F00D
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       ofs,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              pwr_dn_req,
   input  logic              sticky,
   output logic [DATA_W-1:0] rdata,
   output logic              sw_lock,
   output logic              os_lock
);

   localparam logic [DATA_W-1:0] ID_W  = DATA_W'(ID_VALUE);
   localparam logic [DATA_W-1:0] KEY_W = DATA_W'(UNLOCK_KEY);

   logic [DATA_W-1:0] ecr_q;
   logic [DATA_W-1:0] rcr_q;
   logic              sw_lock_q;
   logic              os_lock_q;
   logic [DATA_W-1:0] gen_q [NUM_GEN];
   logic [NUM_GEN-1:0] gen_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecr_q     <= '0;
         rcr_q     <= '0;
         sw_lock_q <= 1'b1;
         os_lock_q <= 1'b0;
      end else if (wr_en) begin
         case (ofs)
            OFS_ECR: ecr_q     <= wdata;
            OFS_RCR: rcr_q     <= wdata;
            OFS_OSL: os_lock_q <= wdata[0];
            OFS_LAR: sw_lock_q <= (wdata != KEY_W);
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_GEN; i++) begin : g_bank
      assign gen_hit[i] = (ofs == 12'(OFS_GEN_BASE + 12'(4 * i)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gen_q[i] <= '0;
         else if (wr_en && gen_hit[i])
            gen_q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (ofs)
         OFS_ID:  rdata = ID_W;
         OFS_ECR: rdata = ecr_q;
         OFS_RCR: rdata = rcr_q;
         OFS_OSL: rdata[0] = os_lock_q;
         OFS_PSR: begin
            rdata[1] = sticky;
            rdata[0] = pwr_dn_req;
         end
         OFS_LSR: rdata[1] = sw_lock_q;
         default: ;
      endcase
      for (int i = 0; i < NUM_GEN; i++)
         if (gen_hit[i]) rdata = gen_q[i];
   end

   assign sw_lock = sw_lock_q;
   assign os_lock = os_lock_q;

   AST_SWLOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sw_lock_q)); // R10

   AST_ECR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ecr_q)); // R3

endmodule

// File: rtl/dbg_apb_gate.sv
module dbg_apb_gate
   import dbg_gate_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          NUM_GEN    = 8,
   parameter logic [31:0] ID_VALUE   = 32'h4D0B_1E57,
   parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_F00D
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              pwr_dn_req
);

   localparam int EXT_BIT = ADDR_W - 1;

   if (ADDR_W < 13 || ADDR_W > 64) begin : g_bad_addr
      $error("dbg_apb_gate: ADDR_W must lie in 13..64");
   end
   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data
      $error("dbg_apb_gate: DATA_W must lie in 8..32");
   end
   if (NUM_GEN < 1 || NUM_GEN > 64) begin : g_bad_gen
      $error("dbg_apb_gate: NUM_GEN must lie in 1..64");
   end

   logic [11:0]       ofs;
   logic              access;
   logic              from_ext;
   acc_cls_e          cls;
   logic              is_lar;
   logic              is_psr;
   logic              err;
   logic              wr_en;
   logic              sticky;
   logic              sw_lock;
   logic              os_lock;
   logic [DATA_W-1:0] rdata_raw;
   logic              unused_addr;

   assign ofs         = paddr[11:0];
   assign from_ext    = paddr[EXT_BIT];
   assign access      = psel && penable;
   assign unused_addr = ^paddr[ADDR_W-2:12];

   dbg_addr_decode u_dec (
      .ofs    (ofs),
      .cls    (cls),
      .is_lar (is_lar),
      .is_psr (is_psr)
   );

   dbg_access_policy u_pol (
      .clk        (clk),
      .rst_n      (rst_n),
      .access     (access),
      .pwrite     (pwrite),
      .from_ext   (from_ext),
      .cls        (cls),
      .is_lar     (is_lar),
      .is_psr     (is_psr),
      .pwr_dn_req (pwr_dn_req),
      .os_lock    (os_lock),
      .sw_lock    (sw_lock),
      .err        (err),
      .wr_en      (wr_en),
      .sticky     (sticky)
   );

   dbg_reg_model #(
      .DATA_W     (DATA_W),
      .NUM_GEN    (NUM_GEN),
      .ID_VALUE   (ID_VALUE),
      .UNLOCK_KEY (UNLOCK_KEY)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ofs        (ofs),
      .wdata      (pwdata),
      .wr_en      (wr_en),
      .pwr_dn_req (pwr_dn_req),
      .sticky     (sticky),
      .rdata      (rdata_raw),
      .sw_lock    (sw_lock),
      .os_lock    (os_lock)
   );

   assign pready  = access;
   assign pslverr = err;
   assign prdata  = err ? '0 : rdata_raw;

   AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> pready && psel && penable); // R9

   AST_NONGEN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      access && cls != CLS_GEN |-> !pslverr); // R7

   AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      access && pwrite && sw_lock && !from_ext && !is_lar |-> !wr_en); // R3

   AST_EXT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      access && pwrite && from_ext && !pslverr |-> wr_en); // R2

endmodule

// File: tb/dbg_apb_gate_tb.sv
`timescale 1ns/1ps
module dbg_apb_gate_tb;

   localparam logic [31:0] ID_V  = 32'h4D0B_1E57;
   localparam logic [31:0] KEY_V = 32'hC0DE_F00D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [31:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic        pwr = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit          chk_data;
      logic [31:0] d;
      bit          e;
      string       tag;
   } item_t;
   item_t exp_q[$];

   always #4 clk = ~clk;

   dbg_apb_gate u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .psel       (psel),
      .penable    (penable),
      .pwrite     (pwrite),
      .paddr      (paddr),
      .pwdata     (pwdata),
      .prdata     (prdata),
      .pready     (pready),
      .pslverr    (pslverr),
      .pwr_dn_req (pwr)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per access phase
   always @(negedge clk) begin
      if (psel && penable) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", 32'h0, 32'h1);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check(pready === 1'b1, {it.tag, " R9 pready"}, {31'b0, pready}, 32'h1);
            check(pslverr === it.e, {it.tag, " pslverr"}, {31'b0, pslverr}, {31'b0, it.e});
            if (it.chk_data && !it.e)
               check(prdata === it.d, {it.tag, " prdata"}, prdata, it.d);
         end
      end
   end

   task automatic xfer(input bit ext, input bit wr, input logic [11:0] ofs,
                       input logic [31:0] wd, input bit chk, input logic [31:0] ed,
                       input bit ee, input string tag, input bit raise);
      item_t it;
      it.chk_data = chk;
      it.d = ed;
      it.e = ee;
      it.tag = tag;
      @(posedge clk); #1;
      psel = 1'b1; penable = 1'b0; pwrite = wr;
      paddr = {ext, 19'b0, ofs}; pwdata = wd;
      exp_q.push_back(it);
      @(posedge clk); #1;
      penable = 1'b1;
      if (raise) pwr = 1'b1;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd(input bit ext, input logic [11:0] ofs, input logic [31:0] ed,
                     input bit ee, input string tag);
      xfer(ext, 1'b0, ofs, '0, 1'b1, ed, ee, tag, 1'b0);
   endtask

   task automatic wr(input bit ext, input logic [11:0] ofs, input logic [31:0] wd,
                     input bit ee, input string tag);
      xfer(ext, 1'b1, ofs, wd, 1'b0, '0, ee, tag, 1'b0);
   endtask

   task automatic set_pwr(input bit v);
      @(posedge clk); #1; pwr = v;
      @(posedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(pready === 1'b0 && pslverr === 1'b0, "R9 idle outputs",
            {30'b0, pready, pslverr}, 32'h0);

      // R1 reset state, R4 locked read of power status leaves sticky set
      rd(1'b0, 12'hF14, 32'h2, 1'b0, "R1 psr after reset");
      rd(1'b0, 12'hF14, 32'h2, 1'b0, "R4 locked psr read kept sticky");
      rd(1'b0, 12'hFB4, 32'h2, 1'b0, "R1 lock status after reset");
      rd(1'b0, 12'hF10, 32'h0, 1'b0, "R1 os lock after reset");

      // R3 locked write dropped, R2 external write accepted
      wr(1'b0, 12'h024, 32'h55, 1'b0, "R3 locked ecr write");
      rd(1'b0, 12'h024, 32'h0, 1'b0, "R3 ecr unchanged");
      wr(1'b1, 12'h024, 32'hA5, 1'b0, "R2 external ecr write");
      rd(1'b0, 12'h024, 32'hA5, 1'b0, "R2 ecr updated");

      // R6 sticky blocks general registers
      rd(1'b0, 12'h100, 32'h0, 1'b1, "R6 gen read while sticky");
      rd(1'b1, 12'hF14, 32'h2, 1'b0, "R5 psr read clearing");
      rd(1'b1, 12'hF14, 32'h0, 1'b0, "R5 sticky cleared");

      wr(1'b0, 12'h100, 32'h1234, 1'b0, "R3 locked gen write");
      rd(1'b0, 12'h100, 32'h0, 1'b0, "R3 gen unchanged");

      // R10 lock word
      wr(1'b0, 12'hFB0, 32'h0, 1'b0, "R10 wrong key");
      rd(1'b0, 12'hFB4, 32'h2, 1'b0, "R10 still locked");
      wr(1'b0, 12'hFB0, KEY_V, 1'b0, "R10 key write");
      rd(1'b0, 12'hFB4, 32'h0, 1'b0, "R10 unlocked");
      wr(1'b0, 12'h104, 32'hBEEF, 1'b0, "R3 unlocked gen write");
      rd(1'b0, 12'h104, 32'hBEEF, 1'b0, "R3 gen written");

      // power-down request
      set_pwr(1'b1);
      rd(1'b0, 12'h104, 32'h0, 1'b1, "R6 gen read powered down");
      wr(1'b0, 12'h104, 32'h1, 1'b1, "R6 gen write powered down");
      rd(1'b0, 12'h000, ID_V, 1'b0, "R7 id while powered down");
      wr(1'b0, 12'h090, 32'h3, 1'b0, "R7 rcr write powered down");
      rd(1'b0, 12'h090, 32'h3, 1'b0, "R7 rcr readback");
      rd(1'b0, 12'hF04, 32'h0, 1'b0, "R8 lowest mgmt offset");
      rd(1'b0, 12'hF00, 32'h0, 1'b1, "R8 0xF00 is general");
      rd(1'b0, 12'hF14, 32'h3, 1'b0, "R5 sticky set by edge");
      rd(1'b0, 12'hF14, 32'h1, 1'b0, "R5 cleared with request high");
      set_pwr(1'b0);
      rd(1'b0, 12'h104, 32'hBEEF, 1'b0, "R6 erroring write discarded");

      // R11 OS lock
      wr(1'b0, 12'hF10, 32'h1, 1'b0, "R11 set os lock");
      rd(1'b0, 12'hF10, 32'h1, 1'b0, "R11 os lock readback");
      rd(1'b0, 12'h104, 32'h0, 1'b1, "R6 gen read under os lock");
      rd(1'b0, 12'h024, 32'hA5, 1'b0, "R7 ecr under os lock");
      wr(1'b0, 12'hF10, 32'h0, 1'b0, "R11 clear os lock");
      rd(1'b0, 12'h104, 32'hBEEF, 1'b0, "R11 gen open again");

      // R5 set wins over a clearing read in the same cycle
      xfer(1'b0, 1'b0, 12'hF14, '0, 1'b1, 32'h1, 1'b0, "R5 read at rising edge", 1'b1);
      rd(1'b0, 12'hF14, 32'h3, 1'b0, "R5 set won");
      rd(1'b0, 12'hF14, 32'h1, 1'b0, "R5 cleared after");
      set_pwr(1'b0);
      rd(1'b0, 12'hF14, 32'h0, 1'b0, "R5 all clear");

      repeat (3) @(posedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
      finish_run();
   end

endmodule